// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog timer that software reaches over a plain register bus. A down-counter runs on the source clock. It is loaded from a programmable timeout that is counted in coarse units of 2^UNIT_SHIFT cycles (4096 by default). If software does not kick the watchdog before the counter runs out, the block acts according to its mode. In reset mode it pulses a reset output, and it can also drive an external reset pin. In interrupt mode it raises a sticky interrupt flag.

The control word changes only when a write carries a 16-bit magic key in its upper half, so a stray store cannot disable the timer. Starting and stopping the count, and kicking the counter, do not happen at once. Each completes after a fixed settling delay of SYNC_DLY cycles. Software polls an enable-status bit or a busy trigger bit to see when the request has finished. The remaining count is readable at any time.

Register map, as byte offsets: 0x0 control, 0x4 status, 0x8 trigger, 0xC manual reset.

Top module: `guarded_watchdog`

## Requirements
- R1: A write to offset 0x0 changes the control word only when wdata[31:16] equals 0x5A96; any other key leaves it unchanged. The control word reads back as enable on bit 0, mode on bit 1 (0 = reset, 1 = interrupt), external-reset enable on bit 2, and the timeout field on bits [8 +: TMO_W], with all other bits reading 0.
- R2: After reset, every register reads 0 and the outputs wdt_rst_o, ext_rst_o and irq_o are 0.
- R3: Status bit 0 (enable status) takes the value of the control enable bit SYNC_DLY clock edges after the write that changed it.
- R4: On the edge where enable status rises, the counter loads timeout << UNIT_SHIFT. While enabled, it then drops by one each cycle. Status bits [8 +: TMO_W+UNIT_SHIFT] show its value.
- R5: Writing 1 to bit 0 of offset 0x8 makes that bit read 1. It clears SYNC_DLY edges after the write, and on that same edge the counter reloads to timeout << UNIT_SHIFT.
- R6: In reset mode, the edge after the counter reads 0 while enabled drives wdt_rst_o high for one cycle and reloads the counter. ext_rst_o pulses together with it only when the external-reset bit is 1.
- R7: In interrupt mode, expiry sets status bit 1 and irq_o and gives no reset pulse. Writing 1 to status bit 1 clears the flag; writing 0 leaves it set.
- R8: Writing 1 to bit 0 of offset 0xC while enable status is 1 pulses wdt_rst_o on the edge of that write. While enable status is 0, such a write has no effect.
- R9: While enable status and the enable bit are both 0, the counter holds its value and no expiry happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdt_rst_o | output | 1 | Internal reset pulse |
| ext_rst_o | output | 1 | External reset pin pulse |
| irq_o | output | 1 | Expiry interrupt (level) |

## Verification
The bench builds the block with UNIT_SHIFT = 4, TMO_W = 4 and SYNC_DLY = 3. A timeout unit is then 16 cycles, so a full countdown of 16 or 32 cycles and an expiry fit inside a few dozen cycles. This makes the exact edge of every reload and expiry reachable. The three-cycle settling delay lets the bench poll the enable-status and trigger bits and see them before and after their completion edge.

// File: rtl/guarded_watchdog_pkg.sv
// Shared constants and types for the key-guarded watchdog.
// Assumes a 32-bit data bus and byte offsets on 4-byte strides.
package guarded_watchdog_pkg;

    localparam logic [15:0] UNLOCK_KEY = 16'h5A96;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_STAT = 4'h4;
    localparam logic [3:0] OFS_KICK = 4'h8;
    localparam logic [3:0] OFS_MRST = 4'hC;

    typedef enum logic {
        WD_MODE_RESET = 1'b0,
        WD_MODE_IRQ   = 1'b1
    } wd_mode_e;

endpackage

// File: rtl/wd_ctrl_regs.sv
// Control word with key check, sticky interrupt flag and manual-reset decode.
// Assumes the write strobes are one-cycle pulses already decoded by address.
module wd_ctrl_regs
    import guarded_watchdog_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_stat,
    input  logic             wr_mrst,
    input  logic [15:0]      wr_key,
    input  logic [TMO_W-1:0] wr_tmo,
    input  logic [2:0]       wr_low,
    input  logic             expire,
    input  logic             en_st,
    output logic             ctrl_en,
    output wd_mode_e         ctrl_mode,
    output logic             ctrl_ext,
    output logic [TMO_W-1:0] ctrl_tmo,
    output logic             irq_flag,
    output logic             man_hit
);

    logic key_ok;
    assign key_ok = (wr_key == UNLOCK_KEY);

    // Control word: updated only by a keyed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_mode <= WD_MODE_RESET;
            ctrl_ext  <= 1'b0;
            ctrl_tmo  <= '0;
        end else if (wr_ctrl && key_ok) begin
            ctrl_en   <= wr_low[0];
            ctrl_mode <= wd_mode_e'(wr_low[1]);
            ctrl_ext  <= wr_low[2];
            ctrl_tmo  <= wr_tmo;
        end
    end

    // Interrupt flag: set on expiry in interrupt mode, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
        end else if (expire && ctrl_mode == WD_MODE_IRQ) begin
            irq_flag <= 1'b1;
        end else if (wr_stat && wr_low[1]) begin
            irq_flag <= 1'b0;
        end
    end

    // Manual reset request is honoured only while counting is active.
    always_comb begin
        man_hit = wr_mrst && wr_low[0] && en_st;
    end

endmodule

// File: rtl/wd_handshake.sv
// Delayed completion of enable/disable and kick requests.
// Assumes DLY >= 1; each request completes DLY edges after it is issued.
module wd_handshake #(
    parameter int DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_en,
    input  logic kick_req,
    output logic en_st,
    output logic en_load,
    output logic kick_busy,
    output logic kick_done
);

    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] ecnt;
    logic [CW-1:0] kcnt;
    logic          en_settle;

    assign en_settle = (ctrl_en != en_st) && (ecnt == LAST);
    assign en_load   = en_settle && ctrl_en;
    assign kick_done = kick_busy && (kcnt == LAST);

    // Enable status: follows the control bit after DLY cycles of mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_st <= 1'b0;
            ecnt  <= '0;
        end else if (ctrl_en == en_st) begin
            ecnt  <= '0;
        end else if (en_settle) begin
            en_st <= ctrl_en;
            ecnt  <= '0;
        end else begin
            ecnt  <= ecnt + 1'b1;
        end
    end

    // Kick: busy from the request until DLY edges later; requests while busy merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kick_busy <= 1'b0;
            kcnt      <= '0;
        end else if (kick_busy) begin
            if (kick_done) begin
                kick_busy <= 1'b0;
                kcnt      <= '0;
            end else begin
                kcnt      <= kcnt + 1'b1;
            end
        end else if (kick_req) begin
            kick_busy <= 1'b1;
        end
    end

endmodule

// File: rtl/wd_downcount.sv
// Watchdog down-counter: loads on request, expires at zero and reloads.
// Assumes load has priority over expiry in the same cycle.
module wd_downcount #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    assign expire = active && (count == '0) && !load;

    // Counter: load, reload on expiry, else decrement while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= reload;
        end else if (active) begin
            if (count == '0) count <= reload;
            else             count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/guarded_watchdog.sv
// Top of the key-guarded watchdog: address decode, read mux, reset outputs.
// Assumes one-cycle write strobes and reads that sample bus_rdata combinationally.
module guarded_watchdog
    import guarded_watchdog_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int TMO_W      = 8,
    parameter int UNIT_SHIFT = 12,
    parameter int SYNC_DLY   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_rst_o,
    output logic              ext_rst_o,
    output logic              irq_o
);

    localparam int CNT_W = TMO_W + UNIT_SHIFT;

    logic             wr_ctrl, wr_stat, wr_kick, wr_mrst;
    logic             ctrl_en, ctrl_ext, irq_flag, man_hit;
    wd_mode_e         ctrl_mode;
    logic [TMO_W-1:0] ctrl_tmo;
    logic             en_st, en_load, trig_busy, kick_done, expire;
    logic [CNT_W-1:0] count, reload;
    logic [31:0]      ctrl_rd, stat_rd;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign wr_ctrl = bus_wen && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_stat = bus_wen && (bus_addr == ADDR_W'(OFS_STAT));
    assign wr_kick = bus_wen && (bus_addr == ADDR_W'(OFS_KICK)) && bus_wdata[0];
    assign wr_mrst = bus_wen && (bus_addr == ADDR_W'(OFS_MRST));

    assign reload = {ctrl_tmo, {UNIT_SHIFT{1'b0}}};

    wd_ctrl_regs #(.TMO_W(TMO_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .wr_mrst(wr_mrst),
        .wr_key(bus_wdata[31:16]), .wr_tmo(bus_wdata[8 +: TMO_W]),
        .wr_low(bus_wdata[2:0]),
        .expire(expire), .en_st(en_st),
        .ctrl_en(ctrl_en), .ctrl_mode(ctrl_mode), .ctrl_ext(ctrl_ext),
        .ctrl_tmo(ctrl_tmo), .irq_flag(irq_flag), .man_hit(man_hit)
    );

    wd_handshake #(.DLY(SYNC_DLY)) u_hs (
        .clk(clk), .rst_n(rst_n),
        .ctrl_en(ctrl_en), .kick_req(wr_kick),
        .en_st(en_st), .en_load(en_load),
        .kick_busy(trig_busy), .kick_done(kick_done)
    );

    wd_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .active(en_st), .load(en_load || kick_done), .reload(reload),
        .count(count), .expire(expire)
    );

    // Reset outputs: one-cycle pulses on reset-mode expiry or manual request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_rst_o <= 1'b0;
            ext_rst_o <= 1'b0;
        end else begin
            wdt_rst_o <= (expire && ctrl_mode == WD_MODE_RESET) || man_hit;
            ext_rst_o <= ((expire && ctrl_mode == WD_MODE_RESET) || man_hit) && ctrl_ext;
        end
    end

    assign irq_o = irq_flag;

    // Read mux: assemble register images and select by address.
    always_comb begin
        ctrl_rd = 32'({ctrl_tmo, 5'b0, ctrl_ext, ctrl_mode, ctrl_en});
        stat_rd = 32'({count, 6'b0, irq_flag, en_st});
        case (bus_addr)
            ADDR_W'(OFS_CTRL): bus_rdata = ctrl_rd;
            ADDR_W'(OFS_STAT): bus_rdata = stat_rd;
            ADDR_W'(OFS_KICK): bus_rdata = 32'(trig_busy);
            default:           bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/guarded_watchdog_checker.sv
// Property checker for guarded_watchdog, attached by bind.
module guarded_watchdog_checker
    import guarded_watchdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wen,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       wr_key,
    input logic [31:0]       ctrl_rd,
    input logic              ctrl_en,
    input logic              en_st,
    input logic              trig_busy,
    input logic              kick_done,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  reload,
    input logic              wdt_rst_o,
    input logic              ext_rst_o
);

    a_r1_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == ADDR_W'(OFS_CTRL) && wr_key != UNLOCK_KEY) |=> $stable(ctrl_rd));

    a_r3_enable_settles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_st) |-> (ctrl_en && $past(ctrl_en)));

    a_r4_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (en_st && !kick_done && count != '0) |=> (count == $past(count) - 1'b1));

    a_r5_kick_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_busy) |-> (count == reload));

    a_r6_ext_with_rst: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_o |-> wdt_rst_o);

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_st && !ctrl_en && !kick_done) |=> $stable(count));

endmodule

bind guarded_watchdog guarded_watchdog_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .wr_key(bus_wdata[31:16]), .ctrl_rd(ctrl_rd), .ctrl_en(ctrl_en),
    .en_st(en_st), .trig_busy(trig_busy), .kick_done(kick_done),
    .count(count), .reload(reload), .wdt_rst_o(wdt_rst_o), .ext_rst_o(ext_rst_o)
);

// File: tb/sim_guarded_watchdog.sv
module sim_guarded_watchdog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wen = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wrst, erst, irq;
    int          checks = 0;
    int          failures = 0;
    logic [31:0] rv;
    logic [31:0] hold;

    always #10 clk = ~clk;

    guarded_watchdog #(.ADDR_W(4), .TMO_W(4), .UNIT_SHIFT(4), .SYNC_DLY(3)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen), .bus_wdata(wdata),
        .bus_rdata(rdata), .wdt_rst_o(wrst), .ext_rst_o(erst), .irq_o(irq)
    );

    // Control write vectors: {write data, expected control readback}
    localparam logic [63:0] VEC [6] = '{
        {32'h5A96_0302, 32'h0000_0302},
        {32'h1234_0105, 32'h0000_0302},
        {32'h5A96_0F04, 32'h0000_0F04},
        {32'h0000_0001, 32'h0000_0F04},
        {32'h5A97_0000, 32'h0000_0F04},
        {32'h5A96_0000, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wen = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic brd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        brd(4'h0, rv); chk("R2 ctrl", rv, 0);
        brd(4'h4, rv); chk("R2 stat", rv, 0);
        brd(4'h8, rv); chk("R2 trig", rv, 0);
        chk("R2 outputs", {29'b0, wrst, erst, irq}, 0);

        // R1 key check via vector table
        foreach (VEC[i]) begin
            bwr(4'h0, VEC[i][63:32]);
            brd(4'h0, rv);
            chk("R1 keyed write", rv, VEC[i][31:0]);
        end

        // R3/R4 enable, reset mode, ext on, timeout 2 -> 32 cycles
        bwr(4'h0, 32'h5A96_0205);
        brd(4'h4, rv); chk("R3 en not yet", rv & 1, 0);
        waitn(2);
        brd(4'h4, rv); chk("R3 en edge-1", rv & 1, 0);
        waitn(1);
        brd(4'h4, rv); chk("R3 en status", rv & 1, 1);
        chk("R4 load", (rv >> 8) & 32'hFF, 32);
        waitn(5);
        brd(4'h4, rv); chk("R4 decrement", (rv >> 8) & 32'hFF, 27);

        // R5 kick
        bwr(4'h8, 32'h1);
        brd(4'h8, rv); chk("R5 busy", rv, 1);
        waitn(2);
        brd(4'h8, rv); chk("R5 busy edge-1", rv, 1);
        waitn(1);
        brd(4'h8, rv); chk("R5 done", rv, 0);
        brd(4'h4, rv); chk("R5 reload", (rv >> 8) & 32'hFF, 32);

        // R6 reset-mode expiry
        waitn(32);
        brd(4'h4, rv); chk("R6 count zero", (rv >> 8) & 32'hFF, 0);
        chk("R6 no early rst", {31'b0, wrst}, 0);
        waitn(1);
        chk("R6 rst pulse", {30'b0, wrst, erst}, 3);
        brd(4'h4, rv); chk("R6 reload", (rv >> 8) & 32'hFF, 32);
        chk("R6 no irq", {31'b0, irq}, 0);
        waitn(1);
        chk("R6 one cycle", {30'b0, wrst, erst}, 0);

        // R8 manual reset while enabled
        bwr(4'hC, 32'h1);
        chk("R8 manual rst", {30'b0, wrst, erst}, 3);
        waitn(1);
        chk("R8 manual end", {31'b0, wrst}, 0);

        // R9 disable then hold
        bwr(4'h0, 32'h5A96_0204);
        waitn(3);
        brd(4'h4, rv); chk("R9 en off", rv & 1, 0);
        hold = (rv >> 8) & 32'hFF;
        waitn(10);
        brd(4'h4, rv); chk("R9 count held", (rv >> 8) & 32'hFF, hold);
        bwr(4'hC, 32'h1);
        chk("R8 ignored when off", {31'b0, wrst}, 0);

        // R7 interrupt mode, timeout 1 -> 16 cycles
        bwr(4'h0, 32'h5A96_0102);
        bwr(4'h0, 32'h5A96_0103);
        waitn(3);
        brd(4'h4, rv); chk("R4 irq-mode load", (rv >> 8) & 32'hFF, 16);
        waitn(16);
        chk("R7 no early irq", {31'b0, irq}, 0);
        waitn(1);
        chk("R7 irq set", {31'b0, irq}, 1);
        chk("R7 no rst", {31'b0, wrst}, 0);
        brd(4'h4, rv); chk("R7 status flag", (rv >> 1) & 1, 1);
        bwr(4'h4, 32'h0);
        chk("R7 write0 keeps", {31'b0, irq}, 1);
        bwr(4'h4, 32'h2);
        chk("R7 w1c", {31'b0, irq}, 0);

        // R1 bad key while running has no effect at the ports
        bwr(4'h0, 32'h1234_0000);
        waitn(4);
        brd(4'h4, rv); chk("R1 still enabled", rv & 1, 1);
        brd(4'h0, rv); chk("R1 ctrl kept", rv, 32'h0000_0103);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule